// File: doc/BRIEF.md
# Serial Configuration Loader

This block loads a bitstream into an FPGA through that device's serial slave configuration pins. A single `start` pulse opens the sequence. The block pulls the program line low and waits until the target drives its init line low, which shows that the target has cleared its configuration memory. It then releases the program line and waits until the init line returns high. After that it shifts each byte of the stream, most significant bit first, onto `din` under a configuration clock that it generates itself.

Before each byte the block checks the two status pins. If init is low while done is still low, the target has reported a checksum fault, and the block stops with an error. Once the last byte has gone out, the block holds `din` high and keeps pulsing the configuration clock, one bit at a time, until done rises or the wait limit runs out. All wait limits are cycle counters sized from the system clock frequency and a time in microseconds. The target pins are asynchronous, so each one passes through two flip-flops before the control logic uses it.

Bytes enter on a valid/ready stream. `in_ready` is high only when three conditions hold: the block is in its data phase, the shifter is idle between bytes, and at least one of the `stream_len` bytes is still owed. The upstream source may hold `in_valid` high for as long as it likes. A byte is taken only on a cycle where both `in_valid` and `in_ready` are high. The block does not time out the stream while it waits for data.

Top module: `cfgs_loader`

## Requirements
- R1: A `start` pulse while `busy` is low begins a load. On the next cycle `busy` is high, `prog_n` is low, and `success` and `error` are both low. A `start` pulse while `busy` is high is ignored and has no effect on the pins or on the load in progress.
- R2: `prog_n` stays low until the synchronised `init_n` has been seen low. It is then released.
- R3: After `prog_n` is released, no configuration clock falls and `in_ready` stays low until `init_n` has returned high.
- R4: If either init wait lasts longer than `WAIT_US` microseconds, the block stops with `error` high and `err_code` = 1. It leaves `prog_n` high and `busy` low.
- R5: Each accepted byte produces exactly eight rising edges of `cclk`, carrying bits 7 down to 0 on `din`. `din` is stable across every rising edge.
- R6: Every low phase of `cclk` lasts exactly `HALF_CYC` system clocks.
- R7: `in_ready` is high only in the data phase, with the shifter idle and bytes still owed. Exactly `stream_len` bytes are accepted. A length of 0 skips straight to the done phase.
- R8: If `init_n` is low and `done` is low when the shifter is idle between bytes, the block stops with `error` high and `err_code` = 2, and it accepts no further byte.
- R9: After the last byte, every further rising edge of `cclk` carries `din` = 1. Pulsing continues until `done` is high, and the block then ends with `success` high and `err_code` = 0.
- R10: If `done` stays low for `WAIT_US` microseconds after the data ends, the block stops with `error` high and `err_code` = 3.
- R11: `success` and `error` are never high together. Each holds its value until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a load |
| stream_len | input | LEN_W | Number of bytes to load, captured on start |
| in_valid | input | 1 | Stream byte is valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block will take the byte this cycle |
| busy | output | 1 | A load is in progress |
| success | output | 1 | Last load ended with done high |
| error | output | 1 | Last load ended with a fault |
| err_code | output | 2 | 0 none, 1 init timeout, 2 checksum fault, 3 done timeout |
| prog_n | output | 1 | Program line to target, active low |
| cclk | output | 1 | Configuration clock; target samples on rising edge |
| din | output | 1 | Serial configuration data |
| init_n | input | 1 | Target init/fault line, active low |
| done | input | 1 | Target done line, high when configured |

## Verification
The hardest case to reach is the checksum fault. It has to appear on the pins after a given byte has finished shifting and before the next byte is taken, while the init line is already back high from the handshake. The bench drives a behavioural target that counts rising configuration-clock edges and pulls `init_n` low once two bytes have gone out. The stream driver spaces its bytes apart, so the fault passes through the two-stage synchroniser before the next byte is offered. Separate target settings stop the target from answering each handshake step and from ever raising done. These settings steer the block into each of its three timeout exits.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_WREL,
    ST_LOAD,
    ST_POST
  } ld_state_t;

  typedef enum logic [1:0] {
    EC_NONE = 2'd0,
    EC_INIT = 2'd1,
    EC_CRC  = 2'd2,
    EC_DONE = 2'd3
  } err_code_t;
endpackage

// File: rtl/cfgs_sync.sv
module cfgs_sync #(
  parameter int          W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/cfgs_timer.sv
module cfgs_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic expired
);
  localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIM);
endmodule

// File: rtl/cfgs_shifter.sv
module cfgs_shifter #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       one_bit,
  input  logic [7:0] byte_in,
  output logic       busy,
  output logic       cclk,
  output logic       din
);
  localparam int HW = (HALF < 2) ? 1 : $clog2(HALF);
  localparam logic [HW-1:0] HRELOAD = HW'(HALF - 1);

  logic [7:0]    sr;
  logic [3:0]    bits_left;
  logic [HW-1:0] hcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr        <= '0;
      bits_left <= '0;
      hcnt      <= '0;
      busy      <= 1'b0;
      cclk      <= 1'b1;
      din       <= 1'b1;
    end else if (!busy) begin
      if (load) begin
        busy      <= 1'b1;
        cclk      <= 1'b0;
        din       <= byte_in[7];
        sr        <= {byte_in[6:0], 1'b0};
        bits_left <= one_bit ? 4'd1 : 4'd8;
        hcnt      <= HRELOAD;
      end
    end else if (hcnt != '0) begin
      hcnt <= hcnt - 1'b1;
    end else if (!cclk) begin
      cclk <= 1'b1;
      hcnt <= HRELOAD;
    end else if (bits_left == 4'd1) begin
      busy <= 1'b0;
    end else begin
      cclk      <= 1'b0;
      din       <= sr[7];
      sr        <= {sr[6:0], 1'b0};
      bits_left <= bits_left - 1'b1;
      hcnt      <= HRELOAD;
    end
  end
endmodule

// File: rtl/cfgs_loader.sv
module cfgs_loader
  import cfgs_pkg::*;
#(
  parameter int CLK_HZ   = 100_000_000,
  parameter int WAIT_US  = 10_000,
  parameter int HALF_CYC = 2,
  parameter int LEN_W    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] stream_len,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             busy,
  output logic             success,
  output logic             error,
  output logic [1:0]       err_code,
  output logic             prog_n,
  output logic             cclk,
  output logic             din,
  input  logic             init_n,
  input  logic             done
);
  localparam int TO_CYC = (CLK_HZ / 1_000_000) * WAIT_US;

  ld_state_t        st_q, st_d;
  logic [LEN_W-1:0] remain_q;
  logic             succ_q, err_q;
  err_code_t        code_q;

  logic [1:0] pins_s;
  logic       init_s, done_s;
  logic       to_exp, to_clr;
  logic       sh_busy, sh_load, sh_one;
  logic [7:0] sh_byte;
  logic       crc_hit, take, post_pulse;
  logic       fin_ok, fin_err;
  err_code_t  fin_code;

  cfgs_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({done, init_n}), .q(pins_s)
  );
  assign init_s = pins_s[0];
  assign done_s = pins_s[1];

  cfgs_timer #(.LIMIT(TO_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(to_clr), .expired(to_exp)
  );

  cfgs_shifter #(.HALF(HALF_CYC)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .one_bit(sh_one),
    .byte_in(sh_byte), .busy(sh_busy), .cclk(cclk), .din(din)
  );

  assign crc_hit    = !init_s && !done_s;
  assign in_ready   = (st_q == ST_LOAD) && !sh_busy && (remain_q != '0) && !crc_hit;
  assign take       = in_ready && in_valid;
  assign post_pulse = (st_q == ST_POST) && !sh_busy && !done_s && !to_exp;
  assign sh_load    = take || post_pulse;
  assign sh_one     = (st_q == ST_POST);
  assign sh_byte    = take ? in_data : 8'hFF;
  assign to_clr     = (st_d != st_q);

  always_comb begin
    st_d     = st_q;
    fin_ok   = 1'b0;
    fin_err  = 1'b0;
    fin_code = EC_NONE;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_PROG;
      ST_PROG: begin
        if (!init_s) st_d = ST_WREL;
        else if (to_exp) begin
          st_d = ST_IDLE; fin_err = 1'b1; fin_code = EC_INIT;
        end
      end
      ST_WREL: begin
        if (init_s) st_d = ST_LOAD;
        else if (to_exp) begin
          st_d = ST_IDLE; fin_err = 1'b1; fin_code = EC_INIT;
        end
      end
      ST_LOAD: begin
        if (!sh_busy) begin
          if (crc_hit) begin
            st_d = ST_IDLE; fin_err = 1'b1; fin_code = EC_CRC;
          end else if (remain_q == '0) begin
            st_d = ST_POST;
          end
        end
      end
      ST_POST: begin
        if (done_s && !sh_busy) begin
          st_d = ST_IDLE; fin_ok = 1'b1;
        end else if (to_exp) begin
          st_d = ST_IDLE; fin_err = 1'b1; fin_code = EC_DONE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      remain_q <= '0;
      succ_q   <= 1'b0;
      err_q    <= 1'b0;
      code_q   <= EC_NONE;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && start) begin
        remain_q <= stream_len;
        succ_q   <= 1'b0;
        err_q    <= 1'b0;
        code_q   <= EC_NONE;
      end else begin
        if (take) remain_q <= remain_q - 1'b1;
        if (fin_ok) succ_q <= 1'b1;
        if (fin_err) begin
          err_q  <= 1'b1;
          code_q <= fin_code;
        end
      end
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign prog_n   = (st_q != ST_PROG);
  assign success  = succ_q;
  assign error    = err_q;
  assign err_code = code_q;
endmodule

// File: rtl/cfgs_loader_chk.sv
module cfgs_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       in_ready,
  input logic       busy,
  input logic       success,
  input logic       error,
  input logic [1:0] err_code,
  input logic       prog_n,
  input logic       cclk,
  input logic       din
);
  p_prog_only_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> busy);

  p_start_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (!success && !error && !prog_n));

  p_flags_apart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(success && error));

  p_ready_between_bytes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (cclk && busy && prog_n));

  p_din_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk) |-> $stable(din));

  p_fault_coded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (err_code != 2'd0));

  p_clean_success_r9: assert property (@(posedge clk) disable iff (!rst_n)
    success |-> (err_code == 2'd0));
endmodule

bind cfgs_loader cfgs_loader_chk u_chk (.*);

// File: tb/cfgs_loader_tb.sv
module cfgs_loader_tb;
  localparam int HALF  = 2;
  localparam int LEN_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] stream_len = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, busy, success, error, prog_n, cclk, din;
  logic [1:0] err_code;
  logic init_n = 1'b1;
  logic done = 1'b0;

  always #5 clk = ~clk;

  cfgs_loader #(.CLK_HZ(100_000_000), .WAIT_US(2), .HALF_CYC(HALF), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stream_len(stream_len),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .busy(busy), .success(success), .error(error), .err_code(err_code),
    .prog_n(prog_n), .cclk(cclk), .din(din), .init_n(init_n), .done(done)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Target model knobs and state
  bit hang_enter = 0, hang_release = 0;
  int crc_at = 0, done_at = -1;
  int tstate = 0, dly = 0, relcnt = 0, edges_seen = 0;

  always @(negedge clk) begin
    if (!prog_n) begin
      tstate = 1; relcnt = 0; done = 1'b0;
      if (!hang_enter) begin
        if (dly >= 3) init_n = 1'b0; else dly++;
      end
    end else if (tstate == 1) begin
      dly = 0;
      if (!init_n && !hang_release) begin
        relcnt++;
        if (relcnt >= 6) begin init_n = 1'b1; tstate = 2; end
      end
    end else if (tstate == 2) begin
      if (crc_at > 0 && edges_seen >= 8 * crc_at) init_n = 1'b0;
      if (done_at >= 0 && edges_seen >= done_at) done = 1'b1;
    end
  end

  // Scoreboard
  logic [7:0] exp_q[$];
  logic [7:0] acc = '0;
  int bitcnt = 0, flush_edges = 0, flush_bad = 0;

  always @(posedge cclk) begin
    if (tstate == 2) begin
      edges_seen++;
      if (bitcnt == 0 && exp_q.size() == 0) begin
        flush_edges++;
        if (!din) flush_bad++;
      end else begin
        acc = {acc[6:0], din};
        bitcnt++;
        if (bitcnt == 8) begin
          logic [7:0] want;
          bitcnt = 0;
          want = exp_q.pop_front();
          chk(acc == want, "R5 byte msb-first", acc, want);
        end
      end
    end
  end

  // Pin-level monitors
  logic prev_prog = 1'b1, prev_cclk = 1'b1;
  int lowrun = 0, bad_half = 0, early_act = 0, bad_release = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!prev_prog && prog_n && !hang_enter && init_n) bad_release++;
      if (prev_cclk && !cclk && tstate != 2) early_act++;
      if (in_ready && tstate != 2) early_act++;
      if (!cclk) lowrun++;
      else if (lowrun > 0) begin
        if (lowrun != HALF) bad_half++;
        lowrun = 0;
      end
    end
    prev_prog = prog_n;
    prev_cclk = cclk;
  end

  int accepted = 0;

  task automatic prep(input bit he, input bit hr, input int ca, input int da);
    repeat (20) @(negedge clk);
    hang_enter = he; hang_release = hr; crc_at = ca; done_at = da;
    tstate = 0; dly = 0; relcnt = 0; edges_seen = 0;
    init_n = 1'b1; done = 1'b0;
    flush_edges = 0; flush_bad = 0; bitcnt = 0; accepted = 0;
    exp_q.delete();
  endtask

  task automatic pulse_start(input int len);
    @(negedge clk);
    start = 1'b1; stream_len = LEN_W'(len);
    @(negedge clk);
    start = 1'b0;
    chk(busy && !prog_n && !success && !error, "R1 start begins load",
        {busy, prog_n, success, error}, 4'b1000);
  endtask

  task automatic send(input logic [7:0] b, input int gap);
    repeat (gap) @(negedge clk);
    in_valid = 1'b1; in_data = b;
    while (!in_ready && busy) @(negedge clk);
    if (in_ready) begin
      exp_q.push_back(b);
      accepted++;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk(!busy && prog_n && !success && !error && !in_ready && cclk,
        "R1 reset idle", {busy, prog_n, success, error, in_ready, cclk}, 6'b010001);

    // Normal load of four bytes, with a start pulse during the load
    prep(0, 0, 0, 8 * 4 + 5);
    pulse_start(4);
    send(8'hA5, 0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && prog_n, "R1 start while busy ignored", {busy, prog_n}, 2'b11);
    send(8'h3C, 0);
    send(8'h80, 0);
    send(8'h01, 0);
    wait_idle();
    chk(success && !error && err_code == 2'd0, "R9 success after done", {success, error, err_code}, 4'b1000);
    chk(accepted == 4 && exp_q.size() == 0, "R7 stream_len bytes taken", accepted, 4);
    chk(flush_edges >= 5 && flush_bad == 0, "R9 flush clocks with din high", flush_edges, 5);
    chk(bad_release == 0, "R2 prog held until init low", bad_release, 0);
    chk(early_act == 0, "R3 no clocking before init release", early_act, 0);
    repeat (40) @(negedge clk);
    chk(success && !error, "R11 success persists", {success, error}, 2'b10);

    // Single byte, different pattern
    prep(0, 0, 0, 8 + 2);
    pulse_start(1);
    send(8'h6E, 3);
    wait_idle();
    chk(success && exp_q.size() == 0, "R5 single byte load", success, 1);

    // Zero length goes straight to done phase
    prep(0, 0, 0, 3);
    pulse_start(0);
    wait_idle();
    chk(success && accepted == 0 && flush_edges >= 3, "R7 zero length load", flush_edges, 3);

    // Init never goes low
    prep(1, 0, 0, -1);
    pulse_start(2);
    wait_idle();
    chk(error && err_code == 2'd1 && prog_n && !busy, "R4 init enter timeout", {error, err_code}, 3'b101);
    chk(!success, "R11 flags exclusive", success, 0);

    // Init never released
    prep(0, 1, 0, -1);
    pulse_start(2);
    send(8'h11, 0);
    wait_idle();
    chk(error && err_code == 2'd1 && accepted == 0, "R4 init release timeout", {error, err_code}, 3'b101);
    chk(early_act == 0, "R3 no data while init held low", early_act, 0);

    // Checksum fault after two bytes
    prep(0, 0, 2, -1);
    pulse_start(4);
    send(8'hC3, 0);
    send(8'h5A, 0);
    send(8'hF0, 12);
    send(8'h0F, 0);
    wait_idle();
    chk(error && err_code == 2'd2, "R8 checksum fault reported", err_code, 2);
    chk(accepted == 2 && !in_ready, "R8 no byte after fault", accepted, 2);

    // Done never rises
    prep(0, 0, 0, -1);
    pulse_start(1);
    send(8'h99, 0);
    wait_idle();
    chk(error && err_code == 2'd3, "R10 done timeout", err_code, 3);
    chk(flush_edges > 0 && flush_bad == 0, "R9 flush din high before timeout", flush_bad, 0);
    repeat (40) @(negedge clk);
    chk(error && err_code == 2'd3, "R11 error persists", err_code, 3);

    // Next start clears the flags
    prep(0, 0, 0, 8 + 1);
    pulse_start(1);
    send(8'h42, 0);
    wait_idle();
    chk(success && !error, "R11 cleared then success", {success, error}, 2'b10);

    chk(bad_half == 0, "R6 low phase width", bad_half, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule